// File: doc/BRIEF.md
# Instruction Cycle Register-Transfer Sequencer

This block is the control and register core of a small accumulator machine. Every instruction passes through a fixed set of machine cycles: an instruction fetch, an optional operand-address indirection, an execute cycle, and an interrupt entry cycle when one is pending. Each cycle takes exactly three clock steps. In each step a micro-operation moves a word between the program counter, the memory address register, the memory buffer register, the instruction register and the accumulator.

The block drives a synchronous single-port memory through an address, write data, a read strobe and a write strobe. Read data comes back one step after the read strobe. An interrupt request input can divert the machine into a service routine at a fixed address. When that happens, the return address is written to a fixed save location. Status outputs report the current machine cycle, the step within it, a halted flag and the accumulator value.

The instruction word has 17 bits. It carries an opcode, an indirect flag and a 12-bit operand address. The supported operations are an accumulating add, an interrupt-enable operation and a halt. Every other opcode passes through all its cycles without changing any register.

Top module: `cyc_sequencer`

## Requirements
- R1: While reset is held and immediately after it is released, the block reports fetch cycle at step 0, the accumulator reads 0, both memory strobes are low and the halted flag is low; the program counter and interrupt enable are cleared.
- R2: Word layout is opcode in bits 16..13, indirect flag in bit 12 and address in bits 11..0. Opcode 1 is ADD, opcode 2 sets interrupt enable, opcode 15 is HALT. Any other opcode changes no register.
- R3: Fetch step 0 loads the address register from the program counter. Step 1 raises the read strobe at that address and increments the program counter. In step 2, the word returned by memory is loaded into the buffer register and the instruction register.
- R4: The cycle status reads 0 for fetch, 1 for indirect, 2 for execute and 3 for interrupt, and the step status counts 0, 1, 2. After a fetch, the indirect cycle runs only when the fetched indirect flag is 1; otherwise execute follows directly.
- R5: The indirect cycle reads memory at the instruction's address field in step 1. In step 2 it replaces only the 12-bit address field with the low 12 bits of the returned word, so execute then uses that pointed-to address.
- R6: ADD reads memory at the (possibly rewritten) address field in execute step 1. In execute step 2 it sets the accumulator to accumulator plus that word, modulo 2^17. The accumulator changes in no other step.
- R7: Interrupt entry occurs at the end of execute only when the request is high and interrupt enable was already set before that instruction. Entry clears interrupt enable, so an instruction that sets interrupt enable is not itself followed by an interrupt, and the service routine is not re-entered.
- R8: The interrupt cycle copies the program counter (zero-extended) to the buffer register in step 0. In step 1 it loads the save address into the address register and the service address into the program counter. In step 2 it writes the buffer to memory at the save address. The next fetch starts at the service address.
- R9: A HALT opcode stops the machine in execute step 0 with the halted flag high. From then until reset, no strobe is raised, the status does not advance and the accumulator holds its value.
- R10: The write strobe is raised only in interrupt step 2, and the read and write strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| memRdata | input | 17 | Memory read data, valid one step after the read strobe |
| memAddr | output | 12 | Memory address (address register) |
| memWdata | output | 17 | Memory write data (buffer register) |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| accOut | output | 17 | Accumulator value |
| cycleState | output | 2 | Current machine cycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt |
| stepIdx | output | 2 | Step within the cycle, 0 to 2 |
| halted | output | 1 | High once a HALT has stopped the machine |

## Verification
Directed programs cover three situations. In a direct ADD followed by an indirect ADD, the address sequence on the memory port separates the direct path from the rewritten pointer path. A request held high with and without a prior enable instruction shows whether entry is gated, whether the save word holds the right return address, and whether the service routine is re-entered. A wrapping sum and a no-op opcode check the modular add and that unknown opcodes have no effect. Randomly generated programs then mix direct, indirect and no-op instructions with pointer words whose upper bits are random. For each program, the final accumulator and the exact number of steps until halt are compared with bench-computed values; this exposes a wrong cycle order or an indirect cycle taken when it is not needed.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd1;
  localparam logic [OP_W-1:0] OP_EI   = 4'd2;
  localparam logic [OP_W-1:0] OP_HALT = 4'd15;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_IND   = 2'd1,
    CYC_EXEC  = 2'd2,
    CYC_INTR  = 2'd3
  } cycle_e;

  // register-transfer strobes from control to datapath
  typedef struct packed {
    logic marFromPc;
    logic marFromIr;
    logic marFromSave;
    logic mbrFromPc;
    logic mbrFromMem;
    logic pcInc;
    logic pcFromIsr;
    logic irFromMem;
    logic irAddrFromMem;
    logic accAdd;
  } dp_ctl_t;
endpackage

// File: rtl/cyc_dpath.sv
module cyc_dpath
  import cyc_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned SAVE_ADDR = 'h7FF,
  parameter int unsigned ISR_ADDR  = 'h800,
  localparam int WORD_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [OP_W-1:0]   irOp,
  output logic              rdInd,
  output logic [WORD_W-1:0] accOut
);
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mbr, ir, acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (ctl.marFromPc)        mar <= pc;
      else if (ctl.marFromIr)   mar <= ir[ADDR_W-1:0];
      else if (ctl.marFromSave) mar <= ADDR_W'(SAVE_ADDR);

      if (ctl.mbrFromPc)       mbr <= {{(WORD_W-ADDR_W){1'b0}}, pc};
      else if (ctl.mbrFromMem) mbr <= memRdata;

      if (ctl.pcInc)          pc <= pc + 1'b1;
      else if (ctl.pcFromIsr) pc <= ADDR_W'(ISR_ADDR);

      if (ctl.irFromMem)          ir <= memRdata;
      else if (ctl.irAddrFromMem) ir[ADDR_W-1:0] <= memRdata[ADDR_W-1:0];

      if (ctl.accAdd) acc <= acc + memRdata;
    end
  end

  assign memAddr  = mar;
  assign memWdata = mbr;
  assign irOp     = ir[WORD_W-1 -: OP_W];
  assign rdInd    = memRdata[ADDR_W];
  assign accOut   = acc;
endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
  import cyc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            irq,
  input  logic [OP_W-1:0] irOp,
  input  logic            rdInd,
  output dp_ctl_t         ctl,
  output logic            memRd,
  output logic            memWr,
  output logic [1:0]      cycleState,
  output logic [1:0]      stepIdx,
  output logic            halted
);
  cycle_e     cyc;
  logic [1:0] step;
  logic       haltReg, ieReg;
  logic       haltNow;

  assign haltNow = (cyc == CYC_EXEC) && (step == 2'd0) && (irOp == OP_HALT);

  always_comb begin
    ctl   = '0;
    memRd = 1'b0;
    memWr = 1'b0;
    if (!haltReg) begin
      unique case (cyc)
        CYC_FETCH: case (step)
          2'd0: ctl.marFromPc = 1'b1;
          2'd1: begin memRd = 1'b1; ctl.pcInc = 1'b1; end
          2'd2: begin ctl.mbrFromMem = 1'b1; ctl.irFromMem = 1'b1; end
          default: ;
        endcase
        CYC_IND: case (step)
          2'd0: ctl.marFromIr = 1'b1;
          2'd1: memRd = 1'b1;
          2'd2: begin ctl.mbrFromMem = 1'b1; ctl.irAddrFromMem = 1'b1; end
          default: ;
        endcase
        CYC_EXEC: if (irOp == OP_ADD) begin
          case (step)
            2'd0: ctl.marFromIr = 1'b1;
            2'd1: memRd = 1'b1;
            2'd2: begin ctl.mbrFromMem = 1'b1; ctl.accAdd = 1'b1; end
            default: ;
          endcase
        end
        CYC_INTR: case (step)
          2'd0: ctl.mbrFromPc = 1'b1;
          2'd1: begin ctl.marFromSave = 1'b1; ctl.pcFromIsr = 1'b1; end
          2'd2: memWr = 1'b1;
          default: ;
        endcase
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyc     <= CYC_FETCH;
      step    <= 2'd0;
      haltReg <= 1'b0;
      ieReg   <= 1'b0;
    end else if (!haltReg) begin
      if (haltNow) begin
        haltReg <= 1'b1;
      end else if (step == 2'd2) begin
        step <= 2'd0;
        unique case (cyc)
          CYC_FETCH: cyc <= rdInd ? CYC_IND : CYC_EXEC;
          CYC_IND:   cyc <= CYC_EXEC;
          CYC_EXEC: begin
            if (irOp == OP_EI) ieReg <= 1'b1;
            if (irq && ieReg) begin
              cyc   <= CYC_INTR;
              ieReg <= 1'b0;
            end else begin
              cyc <= CYC_FETCH;
            end
          end
          CYC_INTR:  cyc <= CYC_FETCH;
        endcase
      end else begin
        step <= step + 2'd1;
      end
    end
  end

  assign cycleState = cyc;
  assign stepIdx    = step;
  assign halted     = haltReg;
endmodule

// File: rtl/cyc_sequencer.sv
module cyc_sequencer
  import cyc_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned SAVE_ADDR = 'h7FF,
  parameter int unsigned ISR_ADDR  = 'h800,
  localparam int WORD_W = OP_W + 1 + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irq,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memRd,
  output logic              memWr,
  output logic [WORD_W-1:0] accOut,
  output logic [1:0]        cycleState,
  output logic [1:0]        stepIdx,
  output logic              halted
);
  dp_ctl_t         ctl;
  logic [OP_W-1:0] irOp;
  logic            rdInd;

  cyc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .irq(irq), .irOp(irOp), .rdInd(rdInd),
    .ctl(ctl), .memRd(memRd), .memWr(memWr),
    .cycleState(cycleState), .stepIdx(stepIdx), .halted(halted)
  );

  cyc_dpath #(.ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR), .ISR_ADDR(ISR_ADDR)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .irOp(irOp), .rdInd(rdInd),
    .accOut(accOut)
  );
endmodule

// File: rtl/cyc_checker.sv
module cyc_checker
  import cyc_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int unsigned SAVE_ADDR = 'h7FF,
  localparam int WORD_W = OP_W + 1 + ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRd,
  input logic              memWr,
  input logic [WORD_W-1:0] accOut,
  input logic [1:0]        cycleState,
  input logic [1:0]        stepIdx,
  input logic              halted
);
  assert_fetch_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cycleState == 2'(CYC_FETCH) && stepIdx == 2'd1 && !halted) |-> memRd);

  assert_step_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx != 2'd3);

  assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == 2'd2) |=> (stepIdx == 2'd0));

  assert_acc_only_exec_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(cycleState == 2'(CYC_EXEC) && stepIdx == 2'd2) |=> $stable(accOut));

  assert_save_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cycleState == 2'(CYC_INTR) && stepIdx == 2'd2)
      |-> (memWr && memAddr == ADDR_W'(SAVE_ADDR)));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(accOut) && $stable(stepIdx)));

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!memRd && !memWr));

  assert_write_place_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (cycleState == 2'(CYC_INTR) && stepIdx == 2'd2));

  assert_no_rd_wr_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
endmodule

bind cyc_sequencer cyc_checker #(.ADDR_W(ADDR_W), .SAVE_ADDR(SAVE_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
  .accOut(accOut), .cycleState(cycleState), .stepIdx(stepIdx), .halted(halted)
);

// File: tb/sim_cyc_sequencer.sv
module sim_cyc_sequencer;
  localparam int AW = 12;
  localparam int WW = 17;
  localparam int SAVE = 'h7FF;
  localparam int ISR  = 'h800;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          irq = 1'b0;
  logic [WW-1:0] memRdata = '0;
  logic [AW-1:0] memAddr;
  logic [WW-1:0] memWdata;
  logic          memRd, memWr;
  logic [WW-1:0] accOut;
  logic [1:0]    cycleState, stepIdx;
  logic          halted;

  logic          ldEn = 1'b0;
  logic [AW-1:0] ldAddr = '0;
  logic [WW-1:0] ldData = '0;
  logic [WW-1:0] mem    [4096];
  logic [WW-1:0] shadow [4096];

  int checks = 0, errors = 0, wrCount = 0, cycles = 0;

  always #5 clk = ~clk;

  cyc_sequencer #(.ADDR_W(AW), .SAVE_ADDR(SAVE), .ISR_ADDR(ISR)) u0 (
    .clk(clk), .rstN(rstN), .irq(irq), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memRd(memRd), .memWr(memWr),
    .accOut(accOut), .cycleState(cycleState), .stepIdx(stepIdx), .halted(halted)
  );

  always @(posedge clk) begin
    if (ldEn) mem[ldAddr] <= ldData;
    else if (memWr) mem[memAddr] <= memWdata;
    if (memRd) memRdata <= mem[memAddr];
    if (memWr) wrCount <= wrCount + 1;
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mk(input int op, input int ind, input int adr);
    return {op[3:0], ind[0], adr[AW-1:0]};
  endfunction

  task automatic putWord(input int a, input logic [WW-1:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldAddr = a[AW-1:0]; ldData = d;
    shadow[a[AW-1:0]] = d;
  endtask

  task automatic beginLoad();
    @(negedge clk);
    rstN = 1'b0;
  endtask

  task automatic endLoad();
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic runToHalt(output int n);
    @(negedge clk);
    rstN = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!halted && n < 2000);
  endtask

  task automatic stepAt(input string tag, input int cy, input int st);
    @(negedge clk);
    chk(tag, {cycleState, stepIdx}, {cy[1:0], st[1:0]});
  endtask

  // bench model of a program starting at address 0 and ending at HALT
  function automatic logic [WW-1:0] modelAcc(input int len);
    logic [WW-1:0] a = '0;
    for (int i = 0; i < len; i++) begin
      logic [WW-1:0] w = shadow[i];
      logic [AW-1:0] ea = w[AW-1:0];
      if (w[AW]) ea = shadow[ea][AW-1:0];
      if (w[WW-1 -: 4] == 4'd1) a = a + shadow[ea];
    end
    return a;
  endfunction

  function automatic int modelSteps(input int len);
    int s = 0;
    for (int i = 0; i < len; i++) s += shadow[i][AW] ? 9 : 6;
    return s + 4;
  endfunction

  initial begin
    int n;
    int unused;
    unused = $urandom(32'd7331);

    // ---------- directed: direct then indirect ADD ----------
    beginLoad();
    putWord(0, mk(1, 0, 'h100));
    putWord(1, mk(1, 1, 'h101));
    putWord(2, mk(15, 0, 0));
    putWord('h100, 17'd5);
    putWord('h101, mk(31, 1, 'h200)); // upper bits must be ignored
    putWord('h200, 17'd7);
    endLoad();
    chk("R1 reset state", {cycleState, stepIdx, memRd, memWr, halted}, 7'b0);
    chk("R1 reset acc", accOut, 0);
    @(negedge clk); rstN = 1'b1;
    chk("R1 after release", {cycleState, stepIdx, memRd, memWr}, 6'b0);
    stepAt("R3 fetch s1", 0, 1);
    chk("R3 read at pc0", {memRd, memAddr}, {1'b1, 12'h000});
    stepAt("R3 fetch s2", 0, 2);
    stepAt("R4 direct skips indirect", 2, 0);
    stepAt("R6 exec s1", 2, 1);
    chk("R6 operand read", {memRd, memAddr}, {1'b1, 12'h100});
    stepAt("R6 exec s2", 2, 2);
    chk("R6 acc not yet updated", accOut, 0);
    stepAt("R4 back to fetch", 0, 0);
    chk("R6 acc after add", accOut, 5);
    stepAt("R3 fetch s1 second", 0, 1);
    chk("R3 pc incremented", {memRd, memAddr}, {1'b1, 12'h001});
    stepAt("R3 fetch s2 second", 0, 2);
    stepAt("R4 indirect taken", 1, 0);
    stepAt("R5 ind s1", 1, 1);
    chk("R5 pointer read", {memRd, memAddr}, {1'b1, 12'h101});
    stepAt("R5 ind s2", 1, 2);
    stepAt("R5 exec s0", 2, 0);
    stepAt("R5 exec s1", 2, 1);
    chk("R5 rewritten address", {memRd, memAddr}, {1'b1, 12'h200});
    stepAt("R5 exec s2", 2, 2);
    stepAt("R4 fetch third", 0, 0);
    chk("R5 acc after indirect", accOut, 12);
    stepAt("R9 halt fetch s1", 0, 1);
    stepAt("R9 halt fetch s2", 0, 2);
    stepAt("R9 halt exec s0", 2, 0);
    @(negedge clk);
    chk("R9 halted flag", halted, 1);
    repeat (12) @(negedge clk);
    chk("R9 frozen status", {cycleState, stepIdx, memRd, memWr, halted}, 7'b1000001);
    chk("R9 acc held", accOut, 12);

    // ---------- interrupt with enable ----------
    beginLoad();
    putWord(0, mk(2, 0, 0));
    putWord(1, mk(1, 0, 'h100));
    putWord(2, mk(15, 0, 0));
    putWord('h100, 17'd5);
    putWord(ISR, mk(1, 0, 'h100));
    putWord(ISR + 1, mk(15, 0, 0));
    putWord(SAVE, 17'h1ABCD);
    endLoad();
    irq = 1'b1;
    wrCount = 0;
    runToHalt(n);
    chk("R7 no interrupt after enable op itself", n, 6 + 6 + 3 + 6 + 4);
    chk("R8 service routine ran", accOut, 10);
    chk("R8 return address saved", mem[SAVE], 2);
    chk("R7 single entry", wrCount, 1);

    // ---------- interrupt request without enable ----------
    beginLoad();
    putWord(0, mk(1, 0, 'h100));
    putWord(1, mk(15, 0, 0));
    putWord(SAVE, 17'h1ABCD);
    endLoad();
    wrCount = 0;
    runToHalt(n);
    irq = 1'b0;
    chk("R7 gated when disabled: steps", n, 10);
    chk("R7 gated when disabled: save word", mem[SAVE], 17'h1ABCD);
    chk("R10 no writes", wrCount, 0);

    // ---------- no-op opcode and wrap ----------
    beginLoad();
    putWord(0, mk(3, 0, 'h100));
    putWord(1, mk(1, 0, 'h100));
    putWord(2, mk(1, 0, 'h100));
    putWord(3, mk(15, 0, 0));
    putWord('h100, 17'h1FFFF);
    endLoad();
    runToHalt(n);
    chk("R2 no-op steps", n, 22);
    chk("R6 modular sum", accOut, 17'h1FFFE);

    // ---------- random programs ----------
    for (int p = 0; p < 24; p++) begin
      int len = 1 + int'($urandom % 6);
      beginLoad();
      for (int i = 0; i < len; i++) begin
        int kind = int'($urandom % 4);
        int op   = (kind == 3) ? 3 + int'($urandom % 12) : 1;
        int ind  = (kind == 2) ? 1 : (kind == 3 ? int'($urandom % 2) : 0);
        int adr;
        if (ind == 1) begin
          int tgt = 'h300 + int'($urandom % 256);
          adr = 'h200 + int'($urandom % 256);
          putWord(adr, {5'($urandom), tgt[AW-1:0]});
          putWord(tgt, 17'($urandom));
        end else begin
          adr = 'h100 + int'($urandom % 256);
          putWord(adr, 17'($urandom));
        end
        putWord(i, mk(op, ind, adr));
      end
      putWord(len, mk(15, 0, 0));
      endLoad();
      runToHalt(n);
      chk($sformatf("R4 random prog %0d steps", p), n, modelSteps(len));
      chk($sformatf("R6 random prog %0d acc", p), accOut, modelAcc(len));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule